// File: doc/BRIEF.md
# DMA Channel Interrupt and Start Gate

This block holds the interrupt and start-permission logic of a seven-channel DMA controller. It keeps two registers that software reaches over a 32-bit register port. The first is a channel-permission register, in which one bit per channel allows that channel to run. The second is an interrupt control register that holds enable fields, sticky per-channel completion flags and a master flag. Address generation and the transfers themselves sit in the neighbouring channel engines. They hand this block a write strobe for each channel's control register, together with the written data, and they pulse a completion line when a block finishes.

For every control-register write, the block decides whether that channel may start, and it answers with a one-cycle start pulse. Completion pulses set sticky flags. A flag is cleared when software writes a 1 to its bit. The master flag is recomputed from the new state on every cycle. The single request toward the system interrupt controller is a one-cycle pulse, issued only when the master flag goes from clear to set.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, both registers read 0, no start output is high and the interrupt pulse is low.
- R2: A write to the interrupt control register (reg_sel=1) stores only the data bits in mask 0x00FF803F: bits 5:0, bit 15 (bus error), bits 22:16 (per-channel completion enables) and bit 23 (global enable). Bits 14:6 always read 0.
- R3: Bits 30:24 are completion flags, one per channel (channel n at bit 24+n). On a control register write, a 1 in a flag bit clears that flag and a 0 leaves it unchanged.
- R4: A completion pulse on done_i[n] sets flag bit 24+n only if enable bit 16+n, as held before that cycle, is set. Otherwise the pulse is ignored.
- R5: If a completion pulse and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R6: A pulse on bus_err sets bit 15, and this takes priority over a write of 0 to that bit in the same cycle.
- R7: Bit 31 reads 1 exactly when (bit 23 is set and any flag in bits 30:24 is set) or bit 15 is set. It is re-evaluated from the updated register contents in every cycle.
- R8: irq_pulse is high for one cycle, in the cycle in which bit 31 first reads 1 after having read 0. No pulse is issued while bit 31 stays 1.
- R9: start_o[n] is high for exactly the one cycle after a cycle with ctl_wr[n]=1, ctl_wdata bit 24 = 1 and permission bit 4*n+3 set (as held before that cycle). Otherwise it stays low.
- R10: A write with reg_sel=0 stores all 32 data bits into the permission register.
- R11: reg_rdata shows, without delay, the permission register when reg_sel=0 and the interrupt control register when reg_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the permission register, 1 selects the interrupt control register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ctl_wr | input | 7 | Per-channel control-register write strobes |
| ctl_wdata | input | 32 | Data written to the channel control register (bit 24 = start request) |
| done_i | input | 7 | Per-channel completion pulses |
| bus_err | input | 1 | Bus error pulse |
| start_o | output | 7 | Per-channel start pulses |
| irq_pulse | output | 1 | Request pulse to the system interrupt controller |

## Verification
The bench drives every channel through all four combinations of permission bit and start bit, and it walks a single 1 across every interrupt control bit. A design with a misplaced permission bit or a wrong write mask would start the wrong channel or keep bits that should read 0. The bench also lets a completion collide with a write-1 clear of the same flag, which catches a design that drops a fresh event. It raises a second flag while the master flag is already set, which catches a design that pulses on the level instead of on the edge. Finally, it clears the bus-error bit in the same cycle as a new error, which catches a design that loses the error.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CH_MAX    = 7;
  localparam logic [31:0] WR_MASK   = 32'h00FF_803F;
  localparam int unsigned BERR_BIT  = 15;
  localparam int unsigned CHEN_LSB  = 16;
  localparam int unsigned GEN_BIT   = 23;
  localparam int unsigned FLAG_LSB  = 24;
  localparam int unsigned MFLAG_BIT = 31;
  localparam int unsigned GO_BIT    = 24;
  localparam int unsigned PERM_STEP = 4;
  localparam int unsigned PERM_OFS  = 3;
endpackage

// File: rtl/dma_start_gate.sv
module dma_start_gate
  import dma_irq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic [REG_W-1:0] perm_q,
  output logic [NCH-1:0]   start_o
);
  logic [NCH-1:0] go_d;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned PBIT = PERM_STEP * n + PERM_OFS;
    always_comb go_d[n] = ctl_wr[n] & ctl_wdata[GO_BIT] & perm_q[PBIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_o <= '0;
    else        start_o <= go_d;
  end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int unsigned NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_en,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] chen,
  output logic [NCH-1:0] flags_d,
  output logic [NCH-1:0] flags_q
);
  logic [NCH-1:0] clr_m;
  logic [NCH-1:0] set_m;

  always_comb begin
    clr_m   = clr_en ? clr_bits : '0;
    set_m   = done_i & chen;
    // a fresh completion outranks a clear of the same flag
    flags_d = (flags_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/dma_master_eval.sv
module dma_master_eval #(
  parameter int unsigned NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gen_d,
  input  logic           berr_d,
  input  logic [NCH-1:0] flags_d,
  output logic           mflag_q,
  output logic           irq_pulse
);
  logic mflag_d;
  logic irq_d;

  always_comb begin
    mflag_d = (gen_d & (|flags_d)) | berr_d;
    irq_d   = mflag_d & ~mflag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag_q   <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      mflag_q   <= mflag_d;
      irq_pulse <= irq_d;
    end
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int unsigned NCH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic [NCH-1:0]   done_i,
  input  logic             bus_err,
  output logic [NCH-1:0]   start_o,
  output logic             irq_pulse
);
  localparam int unsigned LOW_W = FLAG_LSB;

  // reset: asserted at once, released on the clock
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic             icr_wr, perm_wr;
  logic [REG_W-1:0] perm_q, perm_d;
  logic [LOW_W-1:0] low_q, low_d;
  logic [NCH-1:0]   flags_d, flags_q;
  logic             mflag_q;
  logic [CH_MAX-1:0] flag_field;
  logic [REG_W-1:0] icr_q;

  always_comb begin
    icr_wr  = reg_wr & reg_sel;
    perm_wr = reg_wr & ~reg_sel;
    perm_d  = perm_wr ? reg_wdata : perm_q;
    low_d   = icr_wr ? (reg_wdata[LOW_W-1:0] & WR_MASK[LOW_W-1:0]) : low_q;
    if (bus_err) low_d[BERR_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      perm_q <= '0;
      low_q  <= '0;
    end else begin
      if (perm_wr)          perm_q <= perm_d;
      if (icr_wr | bus_err) low_q  <= low_d;
    end
  end

  dma_flag_bank #(.NCH(NCH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr_en   (icr_wr),
    .clr_bits (reg_wdata[FLAG_LSB +: NCH]),
    .done_i   (done_i),
    .chen     (low_q[CHEN_LSB +: NCH]),
    .flags_d  (flags_d),
    .flags_q  (flags_q)
  );

  dma_master_eval #(.NCH(NCH)) u_master (
    .clk       (clk),
    .rst_n     (rst_sn),
    .gen_d     (low_d[GEN_BIT]),
    .berr_d    (low_d[BERR_BIT]),
    .flags_d   (flags_d),
    .mflag_q   (mflag_q),
    .irq_pulse (irq_pulse)
  );

  dma_start_gate #(.NCH(NCH)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .perm_q    (perm_q),
    .start_o   (start_o)
  );

  if (NCH < CH_MAX) begin : g_pad
    assign flag_field = {{(CH_MAX - NCH){1'b0}}, flags_q};
  end else begin : g_full
    assign flag_field = flags_q;
  end

  assign icr_q     = {mflag_q, flag_field, low_q};
  assign reg_rdata = reg_sel ? icr_q : perm_q;
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk #(
  parameter int unsigned NCH = 7
) (
  input logic           clk,
  input logic           rst_sn,
  input logic           reg_wr,
  input logic           reg_sel,
  input logic [NCH-1:0] ctl_wr,
  input logic [31:0]    ctl_wdata,
  input logic [NCH-1:0] done_i,
  input logic [NCH-1:0] start_o,
  input logic           irq_pulse,
  input logic [31:0]    icr_q
);
  assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_pulse |-> (icr_q[31] && !$past(icr_q[31])));

  assert_start_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> ((start_o & ~$past(ctl_wr)) == '0));

  assert_start_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctl_wdata[24] |=> (start_o == '0));

  assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    ((done_i & icr_q[16 +: NCH]) != '0) |=>
      ((icr_q[24 +: NCH] & $past(done_i & icr_q[16 +: NCH])) == $past(done_i & icr_q[16 +: NCH])));

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(reg_wr && reg_sel) && done_i == '0) |=> $stable(icr_q[30:24]));

  assert_master_consistent_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    icr_q[31] == ((icr_q[23] && (|icr_q[30:24])) || icr_q[15]));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    icr_q[14:6] == '0);
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .done_i    (done_i),
  .start_o   (start_o),
  .irq_pulse (irq_pulse),
  .icr_q     (icr_q)
);

// File: tb/sim_dma_irq_unit.sv
module sim_dma_irq_unit;
  localparam int NCH = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [6:0]  ctl_wr, done_i, start_o;
  logic [31:0] ctl_wdata;
  logic        bus_err, irq_pulse;

  int vecs = 0;
  int errs = 0;
  logic [31:0] m_icr, m_en;

  always #4 clk = ~clk; // 125 MHz

  dma_irq_unit #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .done_i(done_i), .bus_err(bus_err),
    .start_o(start_o), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    reg_sel = 1'b1; #1;
    chk({tag, " icr"}, reg_rdata, m_icr);
    reg_sel = 1'b0; #1;
    chk({tag, " perm R10/R11"}, reg_rdata, m_en);
  endtask

  // one clock of stimulus; expected state computed from the requirements
  task automatic apply(input logic wr, input logic sel, input logic [31:0] wd,
                       input logic [6:0] cw, input logic [31:0] cd,
                       input logic [6:0] dn, input logic be, input string tag);
    logic [6:0]  flags, setf, clr, nflags, exp_start;
    logic [31:0] low;
    logic        master, exp_irq;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ctl_wr = cw; ctl_wdata = cd; done_i = dn; bus_err = be;
    flags  = m_icr[30:24];
    setf   = dn & m_icr[22:16];
    clr    = (wr && sel) ? wd[30:24] : 7'h0;
    nflags = (flags & ~clr) | setf;
    low    = ((wr && sel) ? wd : m_icr) & 32'h00FF803F;
    if (be) low[15] = 1'b1;
    master = (low[23] && (|nflags)) || low[15];
    exp_irq = master && !m_icr[31];
    for (int n = 0; n < NCH; n++)
      exp_start[n] = cw[n] && cd[24] && m_en[4*n+3];
    @(posedge clk);
    m_icr = {master, nflags, low[23:0]};
    if (wr && !sel) m_en = wd;
    #2;
    reg_wr = 1'b0; ctl_wr = '0; done_i = '0; bus_err = 1'b0;
    chk({tag, " start R9"}, {25'h0, start_o}, {25'h0, exp_start});
    chk({tag, " irq R8"}, {31'h0, irq_pulse}, {31'h0, exp_irq});
    check_regs(tag);
  endtask

  task automatic idle(input string tag);
    apply(1'b0, 1'b0, 32'h0, 7'h0, 32'h0, 7'h0, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    ctl_wr = '0; ctl_wdata = '0; done_i = '0; bus_err = 1'b0;
    m_icr = '0; m_en = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 start", {25'h0, start_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_pulse}, 32'h0);
    check_regs("R1");

    // R10 plain writes to the permission register
    apply(1'b1, 1'b0, 32'hA5C3_0F1E, '0, '0, '0, 1'b0, "R10 pattern");
    apply(1'b1, 1'b0, 32'h5A3C_F0E1, '0, '0, '0, 1'b0, "R10 inverse");

    // R9 per-channel start: permission bit x start bit
    for (int n = 0; n < NCH; n++)
      for (int eb = 0; eb < 2; eb++)
        for (int sb = 0; sb < 2; sb++) begin
          apply(1'b1, 1'b0, eb ? (32'h1 << (4*n+3)) : ~(32'h1 << (4*n+3)),
                '0, '0, '0, 1'b0, "R9 perm setup");
          apply(1'b0, 1'b0, 32'h0, 7'h1 << n, sb ? 32'h0100_0000 : 32'hFEFF_FFFF,
                '0, 1'b0, "R9 start");
          idle("R9 one-cycle");
        end
    apply(1'b1, 1'b0, 32'h0888_8888, '0, '0, '0, 1'b0, "R9 all perm");
    apply(1'b0, 1'b0, 32'h0, 7'h7F, 32'h0100_0000, '0, 1'b0, "R9 all channels");
    apply(1'b0, 1'b0, 32'h0, 7'h55, 32'h0100_0000, '0, 1'b0, "R9 sparse channels");

    // R2/R7/R8 walking one across the interrupt control register
    for (int b = 0; b < 32; b++) begin
      apply(1'b1, 1'b1, 32'h1 << b, '0, '0, '0, 1'b0, "R2 walk");
      apply(1'b1, 1'b1, 32'h7F00_0000, '0, '0, '0, 1'b0, "R2 clear");
    end
    apply(1'b1, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, 1'b0, "R2 all ones R7");
    apply(1'b1, 1'b1, 32'h0000_0000, '0, '0, '0, 1'b0, "R2 all zero");

    // R4 completion with and without the channel enable, global enable on
    for (int n = 0; n < NCH; n++)
      for (int e = 0; e < 2; e++) begin
        apply(1'b1, 1'b1, 32'h7F80_0000 | (e ? (32'h1 << (16+n)) : 32'h0),
              '0, '0, '0, 1'b0, "R4 setup");
        apply(1'b0, 1'b0, 32'h0, '0, '0, 7'h1 << n, 1'b0, "R4 done R7 R8");
        idle("R4 hold R3");
      end

    // R8 second flag while master already set: no new pulse
    apply(1'b1, 1'b1, 32'h7FFF_0000, '0, '0, '0, 1'b0, "R8 setup");
    apply(1'b0, 1'b0, 32'h0, '0, '0, 7'h01, 1'b0, "R8 first");
    apply(1'b0, 1'b0, 32'h0, '0, '0, 7'h02, 1'b0, "R8 second");
    // R3 clear only one flag, zeros keep the others
    apply(1'b1, 1'b1, 32'h01FF_0000, '0, '0, '0, 1'b0, "R3 partial clear");
    apply(1'b1, 1'b1, 32'h02FF_0000, '0, '0, '0, 1'b0, "R3 last clear R7");
    // R5 collision of completion and clear
    apply(1'b1, 1'b1, 32'h04FF_0000, '0, '0, 7'h04, 1'b0, "R5 collision");
    apply(1'b1, 1'b1, 32'h047F_0000, '0, '0, '0, 1'b0, "R5 clear no gen");
    // R6 bus error pulse, and against a write of 0 in the same cycle
    apply(1'b0, 1'b0, 32'h0, '0, '0, '0, 1'b1, "R6 pulse R8");
    apply(1'b1, 1'b1, 32'h0000_0000, '0, '0, '0, 1'b1, "R6 vs write");
    apply(1'b1, 1'b1, 32'h0000_0000, '0, '0, '0, 1'b0, "R6 cleared");
    apply(1'b0, 1'b0, 32'h0, '0, '0, 7'h7F, 1'b1, "R6 flags masked");
    idle("R7 settle");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule